// File: doc/BRIEF.md
# Programmable Access Strobe Sequencer

This block sets the timing of the two control strobes for a single access to an external card-style memory, either in the common-memory space or in the IO space. Each space has its own configuration word. The word holds three phase lengths and one bus-width flag. Each phase length is written as the number of clock cycles minus one. A one-cycle `start` pulse begins an access. The pulse comes with a write flag and a space select. The block then pulls the address strobe low, pulls the data strobe low inside that window, releases the data strobe, and last releases the address strobe. One cycle later it gives a single-cycle `done`.

The phase lengths and the width flag of the selected space are copied at start. Software may rewrite the configuration at any time without harming an access already in progress. The block has no data stream and no back-pressure. A `start` given while `busy` is high is dropped and is not queued. `start` is accepted again from the cycle in which `busy` returns low.

Top module: `strobe_seq`

## Requirements
- R1: During and right after reset, `adr_n` and `dat_n` are 1, `busy` and `done` are 0, and both configuration words read as zero.
- R2: An accepted start drives `adr_n` low at the next clock edge. `dat_n` stays high for the first (SETUP+1) cycles of that `adr_n`-low window.
- R3: After the setup phase, `dat_n` is low for exactly (ACCESS+1) cycles, for reads and for writes alike.
- R4: After `dat_n` rises, `adr_n` stays low for exactly (HOLD+1) more cycles and then goes high.
- R5: `dat_n` is never low while `adr_n` is high. `dat_n` falls only after `adr_n` has already been low for at least one cycle, and `adr_n` rises only after `dat_n` was high in the previous cycle.
- R6: `busy` is high exactly while `adr_n` is low. `done` is high for one cycle, in the first cycle in which `adr_n` is high again.
- R7: A `start` given while `busy` is high is ignored. The running access keeps its timing, and no second access follows it.
- R8: The phase lengths and the width flag are copied when the access starts. A register write during an access does not change that access.
- R9: `space_io` = 0 selects the common-space word (offset 0) and 1 selects the IO-space word (offset 1). `acc_wide` shows the width flag of the selected word for the whole access.
- R10: In the configuration word, bits [7:0] are SETUP, [15:8] are ACCESS, [23:16] are HOLD and bit 31 is the width flag. Bits [30:24] read as zero.
- R11: `acc_write` shows the value `write_req` had at start, for the whole access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Configuration write enable |
| reg_addr | input | 1 | Word select: 0 common space, 1 IO space |
| reg_wdata | input | 32 | Configuration write data |
| reg_rdata | output | 32 | Read data of the word picked by reg_addr |
| start | input | 1 | Begins an access when idle |
| write_req | input | 1 | 1 for a write access, 0 for a read |
| space_io | input | 1 | Timing set select: 0 common, 1 IO |
| adr_n | output | 1 | Active-low address strobe |
| dat_n | output | 1 | Active-low data strobe |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| acc_write | output | 1 | Captured write flag |
| acc_wide | output | 1 | Captured bus-width flag |

## Verification
Suppose the phase counter or the phase state goes wrong. The strobe edges then move by one or more cycles, and that shows at the pins within the phase in which the fault occurs. The bench compares `adr_n` and `dat_n` on every cycle, so a count that is off by one is caught at the first edge that comes too early or too late. A damaged capture of a length, or of a flag, shows up as a late edge or a wrong `acc_wide` or `acc_write` during the same access. A start that is wrongly accepted shows up as `adr_n` staying low after the expected `done`.

// File: rtl/strobe_seq_pkg.sv
package strobe_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  localparam int NUM_SPACES = 2;

endpackage

// File: rtl/strobe_cfg_regs.sv
module strobe_cfg_regs #(
  parameter int PHASE_W = 8,
  parameter int DATA_W  = 32,
  parameter int NSPACE  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_we,
  input  logic [$clog2(NSPACE)-1:0] reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [DATA_W-1:0]         reg_rdata,
  input  logic [$clog2(NSPACE)-1:0] space_sel,
  output logic [PHASE_W-1:0]        sel_setup,
  output logic [PHASE_W-1:0]        sel_access,
  output logic [PHASE_W-1:0]        sel_hold,
  output logic                      sel_wide
);

  localparam int SEL_W    = $clog2(NSPACE);
  localparam int OFS_SET  = 0;
  localparam int OFS_ACC  = PHASE_W;
  localparam int OFS_HOLD = 2 * PHASE_W;
  localparam int WIDE_BIT = DATA_W - 1;

  logic [PHASE_W-1:0] setup_q [NSPACE];
  logic [PHASE_W-1:0] acc_q   [NSPACE];
  logic [PHASE_W-1:0] hold_q  [NSPACE];
  logic               wide_q  [NSPACE];

  for (genvar g = 0; g < NSPACE; g++) begin : g_space
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        setup_q[g] <= '0;
        acc_q[g]   <= '0;
        hold_q[g]  <= '0;
        wide_q[g]  <= 1'b0;
      end else if (reg_we && (reg_addr == SEL_W'(g))) begin
        setup_q[g] <= reg_wdata[OFS_SET  +: PHASE_W];
        acc_q[g]   <= reg_wdata[OFS_ACC  +: PHASE_W];
        hold_q[g]  <= reg_wdata[OFS_HOLD +: PHASE_W];
        wide_q[g]  <= reg_wdata[WIDE_BIT];
      end
    end
  end

  // Bits that hold no field are not stored, so they read back as zero.
  always_comb begin
    reg_rdata                       = '0;
    reg_rdata[OFS_SET  +: PHASE_W]  = setup_q[reg_addr];
    reg_rdata[OFS_ACC  +: PHASE_W]  = acc_q[reg_addr];
    reg_rdata[OFS_HOLD +: PHASE_W]  = hold_q[reg_addr];
    reg_rdata[WIDE_BIT]             = wide_q[reg_addr];
  end

  assign sel_setup  = setup_q[space_sel];
  assign sel_access = acc_q[space_sel];
  assign sel_hold   = hold_q[space_sel];
  assign sel_wide   = wide_q[space_sel];

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[WIDE_BIT-1:OFS_HOLD+PHASE_W];

endmodule

// File: rtl/strobe_phase_fsm.sv
module strobe_phase_fsm
  import strobe_seq_pkg::*;
#(
  parameter int PHASE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               wr_in,
  input  logic               wide_in,
  input  logic [PHASE_W-1:0] setup_in,
  input  logic [PHASE_W-1:0] access_in,
  input  logic [PHASE_W-1:0] hold_in,
  output logic               adr_n,
  output logic               dat_n,
  output logic               busy,
  output logic               done,
  output logic               acc_write,
  output logic               acc_wide
);

  phase_e             phase_q, phase_d;
  logic [PHASE_W-1:0] cnt_q, cnt_d;
  logic [PHASE_W-1:0] acc_len_q, hold_len_q;
  logic               last_cnt;
  logic               launch;

  assign last_cnt = (cnt_q == '0);
  assign launch   = (phase_q == PH_IDLE) && start;

  // Next phase and counter. The counter is reloaded at every phase change.
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_SETUP;
          cnt_d   = setup_in;
        end
      end
      PH_SETUP: begin
        if (last_cnt) begin
          phase_d = PH_ACCESS;
          cnt_d   = acc_len_q;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_ACCESS: begin
        if (last_cnt) begin
          phase_d = PH_HOLD;
          cnt_d   = hold_len_q;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_HOLD: begin
        if (last_cnt) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  // Copy the access parameters at launch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_len_q  <= '0;
      hold_len_q <= '0;
      acc_write  <= 1'b0;
      acc_wide   <= 1'b0;
    end else if (launch) begin
      acc_len_q  <= access_in;
      hold_len_q <= hold_in;
      acc_write  <= wr_in;
      acc_wide   <= wide_in;
    end
  end

  // The strobes come straight from flops, decoded from the next phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr_n <= 1'b1;
      dat_n <= 1'b1;
      done  <= 1'b0;
    end else begin
      adr_n <= (phase_d == PH_IDLE);
      dat_n <= (phase_d != PH_ACCESS);
      done  <= (phase_q == PH_HOLD) && last_cnt;
    end
  end

  assign busy = (phase_q != PH_IDLE);

endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
  import strobe_seq_pkg::*;
#(
  parameter int PHASE_W = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              start,
  input  logic              write_req,
  input  logic              space_io,
  output logic              adr_n,
  output logic              dat_n,
  output logic              busy,
  output logic              done,
  output logic              acc_write,
  output logic              acc_wide
);

  logic [PHASE_W-1:0] cur_setup, cur_access, cur_hold;
  logic               cur_wide;

  strobe_cfg_regs #(
    .PHASE_W (PHASE_W),
    .DATA_W  (DATA_W),
    .NSPACE  (NUM_SPACES)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .space_sel  (space_io),
    .sel_setup  (cur_setup),
    .sel_access (cur_access),
    .sel_hold   (cur_hold),
    .sel_wide   (cur_wide)
  );

  strobe_phase_fsm #(
    .PHASE_W (PHASE_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .wr_in     (write_req),
    .wide_in   (cur_wide),
    .setup_in  (cur_setup),
    .access_in (cur_access),
    .hold_in   (cur_hold),
    .adr_n     (adr_n),
    .dat_n     (dat_n),
    .busy      (busy),
    .done      (done),
    .acc_write (acc_write),
    .acc_wide  (acc_wide)
  );

endmodule

// File: rtl/strobe_seq_chk.sv
module strobe_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic adr_n,
  input logic dat_n,
  input logic busy,
  input logic done,
  input logic acc_write,
  input logic acc_wide
);

  p_nest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_n |-> !adr_n);

  p_data_after_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dat_n) |-> $past(!adr_n));

  p_addr_after_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adr_n) |-> $past(dat_n));

  p_busy_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !adr_n |-> busy);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_place_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (adr_n && $past(!adr_n)));

  p_flags_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(acc_write) && $stable(acc_wide)));

endmodule

bind strobe_seq strobe_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .adr_n     (adr_n),
  .dat_n     (dat_n),
  .busy      (busy),
  .done      (done),
  .acc_write (acc_write),
  .acc_wide  (acc_wide)
);

// File: tb/sim_strobe_seq.sv
`timescale 1ns/1ps
module sim_strobe_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic        reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        start;
  logic        write_req;
  logic        space_io;
  logic        adr_n, dat_n, busy, done, acc_write, acc_wide;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  strobe_seq u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .start     (start),
    .write_req (write_req),
    .space_io  (space_io),
    .adr_n     (adr_n),
    .dat_n     (dat_n),
    .busy      (busy),
    .done      (done),
    .acc_write (acc_write),
    .acc_wide  (acc_wide)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pack(input int s, input int a, input int h, input bit w);
    return {w, 7'd0, h[7:0], a[7:0], s[7:0]};
  endfunction

  // Called right after a falling edge; returns right after a falling edge.
  task automatic wr(input bit addr, input logic [31:0] data);
    reg_addr  = addr;
    reg_wdata = data;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd_chk(input bit addr, input logic [31:0] exp);
    reg_addr = addr;
    #1;
    chk("R10", "readback", reg_rdata, exp);
  endtask

  task automatic run(input bit io, input bit wrf, input int s, input int a,
                     input int h, input bit wide, input bit poke);
    int t;
    string tag;
    t = s + a + h + 3;
    space_io  = io;
    write_req = wrf;
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
    for (int i = 1; i <= t + 3; i++) begin
      if (i <= s + 1)          tag = "R2";
      else if (i <= s + a + 2) tag = "R3";
      else if (i <= t)         tag = "R4";
      else                     tag = "R7";
      if (poke && i <= t) tag = "R8";
      chk(tag, "adr_n", {31'd0, adr_n}, {31'd0, !(i <= t)});
      chk(tag, "dat_n", {31'd0, dat_n}, {31'd0, !(i >= s + 2 && i <= s + a + 2)});
      chk("R6", "done", {31'd0, done}, {31'd0, (i == t + 1)});
      chk("R6", "busy", {31'd0, busy}, {31'd0, (i <= t)});
      chk("R5", "nesting", {31'd0, (!dat_n && adr_n)}, 32'd0);
      if (i <= t) begin
        chk("R11", "acc_write", {31'd0, acc_write}, {31'd0, wrf});
        chk("R9", "acc_wide", {31'd0, acc_wide}, {31'd0, wide});
      end
      if (poke && i == 2) begin
        start     = 1'b1;
        write_req = !wrf;
        reg_addr  = 1'b0;
        reg_wdata = pack(3, 3, 3, 1'b1) ^ pack(s, a, h, wide);
        reg_we    = 1'b1;
      end
      @(negedge clk);
      start  = 1'b0;
      reg_we = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL all: watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    start = 1'b0; write_req = 1'b0; space_io = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "adr_n in reset", {31'd0, adr_n}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "adr_n", {31'd0, adr_n}, 32'd1);
    chk("R1", "dat_n", {31'd0, dat_n}, 32'd1);
    chk("R1", "busy", {31'd0, busy}, 32'd0);
    chk("R1", "done", {31'd0, done}, 32'd0);
    reg_addr = 1'b0; #1; chk("R1", "common word", reg_rdata, 32'd0);
    reg_addr = 1'b1; #1; chk("R1", "io word", reg_rdata, 32'd0);
    @(negedge clk);

    // Field layout and reserved bits (R10)
    wr(1'b0, 32'hFFFF_FFFF);
    rd_chk(1'b0, 32'h80FF_FFFF);
    rd_chk(1'b1, 32'h0000_0000);
    wr(1'b1, 32'h1234_5678);
    rd_chk(1'b1, 32'h0034_5678);
    wr(1'b1, 32'hFF00_0000);
    rd_chk(1'b1, 32'h8000_0000);
    rd_chk(1'b0, 32'h80FF_FFFF);
    @(negedge clk);

    // Sweep of small phase lengths on both spaces
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 4; a++)
        for (int h = 0; h < 4; h++) begin
          wr(1'b0, pack(s, a, h, 1'b0));
          wr(1'b1, pack(h, s, a, 1'b1));
          run(1'b0, bit'((s ^ a) & 1), s, a, h, 1'b0, (h == 1));
          run(1'b1, bit'(~(s ^ a) & 1), h, s, a, 1'b1, 1'b0);
        end

    // Longer lengths, including the largest field value
    wr(1'b0, pack(0, 16, 0, 1'b1));
    run(1'b0, 1'b1, 0, 16, 0, 1'b1, 1'b1);
    wr(1'b1, pack(255, 255, 255, 1'b0));
    run(1'b1, 1'b0, 255, 255, 255, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule